// File: doc/BRIEF.md
# Privilege and Interrupt-Enable Stack Controller

This block keeps the part of a processor's machine status word that tracks privilege. It holds a three-deep stack of (privilege, interrupt-enable) pairs. Level 0 is the current state and levels 1 and 2 are the saved states beneath it. It also holds the memory-privilege modifier bit and the two-bit floating-point and extension state fields. From those two fields it derives a summary-dirty flag in the top bit of the status word.

A one-cycle trap strobe shifts the stack down, so the core enters machine mode with interrupts off. The same strobe captures the cause and the interrupted PC, and loads a handler address. That address depends on the privilege that was active before the trap. A one-cycle return strobe shifts the stack up. A status write port takes a full machine-view word or a reduced supervisor-view word. In either view, privilege fields are filtered so that the reserved encoding can never be stored.

Top module: `priv_stack_unit`

## Requirements
- R1: After reset, status_o reads 0x00000096. This means level 0 is machine (3) with enable 0, and levels 1 and 2 are supervisor (1) with enable 0. Also after reset, pc_o = VEC_BASE + 0x100, cause_o = 0, epc_o = 0 and pc_load_o = 0. Status layout: bit 0 enable0, [2:1] priv0, bit 3 enable1, [5:4] priv1, bit 6 enable2, [8:7] priv2, bit 9 modifier, [11:10] fp state, [13:12] ext state, bit 31 dirty. All other bits read 0. Privilege codes are user 0, supervisor 1 and machine 3.
- R2: On a trap, level 2 takes the old level 1 and level 1 takes the old level 0. Level 0 becomes machine with enable 0, and the modifier bit clears. The result is visible on status_o one cycle later.
- R3: On a return without a trap, level 0 takes the old level 1 and level 1 takes the old level 2. Level 2 becomes user with enable 1.
- R4: One cycle after a trap, pc_o = VEC_BASE + 0x40 × (the level-0 privilege before the trap), and pc_load_o is high for exactly that cycle. pc_o keeps its value when no trap occurs.
- R5: One cycle after a trap, cause_o and epc_o hold that cycle's trap_cause_i and trap_pc_i. Without a trap, both keep their values.
- R6: When trap and return arrive in the same cycle, only the trap takes effect.
- R7: A machine-view write (wr_sview_i = 0) loads every enable bit, the modifier bit and both state fields from the written word at the status positions. Written bits outside the defined fields have no effect.
- R8: A privilege field written with encoding 2 keeps its old value. Each privilege field is filtered on its own.
- R9: Status bit 31 is 1 exactly when the fp state field or the ext state field equals 3.
- R10: A supervisor-view write (wr_sview_i = 1) takes bit 1 into enable0, bit 4 into enable1 and bits [9:8] into priv1, with the filtering of R8. All other status fields are left unchanged.
- R11: A write in a cycle that has a trap or a return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Trap entry strobe |
| trap_cause_i | input | XLEN | Cause code for the trap |
| trap_pc_i | input | XLEN | PC of the interrupted instruction |
| ret_i | input | 1 | Trap return strobe |
| wr_en_i | input | 1 | Status write enable |
| wr_sview_i | input | 1 | 1 selects the supervisor-view layout |
| wr_data_i | input | XLEN | Written status value |
| status_o | output | XLEN | Machine-view status word |
| cause_o | output | XLEN | Captured trap cause |
| epc_o | output | XLEN | Captured exception PC |
| pc_o | output | XLEN | Handler or reset fetch address |
| pc_load_o | output | 1 | High for one cycle after a trap |

## Verification
Every result is held in a register. The effect of a strobe or write presented before a rising edge appears one edge later. That holds for the stack, for pc_o with the pc_load_o pulse, and for cause_o and epc_o. The bench drives inputs on the falling edge and compares outputs on the next falling edge. That point falls after exactly one rising edge, and before the next vector changes anything. Hold behaviour is checked in the same window, on vectors that carry no trap.

// File: rtl/privstk_pkg.sv
package privstk_pkg;

  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  localparam int DEPTH   = 3;
  localparam int LVL_W   = 3;
  localparam int F_MPRV  = DEPTH * LVL_W;
  localparam int F_FS    = F_MPRV + 1;
  localparam int F_XS    = F_FS + 2;
  localparam int LOW_W   = F_XS + 2;

  localparam int SV_IE   = 1;
  localparam int SV_PIE  = 4;
  localparam int SV_PS   = 8;

  localparam int VEC_SHIFT = 6;

  typedef struct packed {
    logic [1:0] prv;
    logic       ie;
  } lvl_t;

  function automatic lvl_t mk_lvl(input logic [1:0] p, input logic e);
    lvl_t l;
    l.prv = p;
    l.ie  = e;
    return l;
  endfunction

  function automatic logic prv_ok(input logic [1:0] p);
    return (p != 2'd2);
  endfunction

  function automatic logic [1:0] prv_pick(input logic [1:0] old_p, input logic [1:0] new_p);
    return prv_ok(new_p) ? new_p : old_p;
  endfunction

  function automatic logic is_dirty(input logic [1:0] fs, input logic [1:0] xs);
    return (&fs) | (&xs);
  endfunction

  function automatic logic [VEC_SHIFT+1:0] vec_off(input logic [1:0] p);
    return {p, {VEC_SHIFT{1'b0}}};
  endfunction

endpackage

// File: rtl/ps_stack.sv
module ps_stack
  import privstk_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic            wr,
  input  logic            wr_sv,
  input  logic [XLEN-1:0] wr_data,
  output logic [1:0]      cur_prv,
  output logic [XLEN-1:0] status
);

  lvl_t       lv   [DEPTH];
  lvl_t       lv_n [DEPTH];
  logic       mprv, mprv_n;
  logic [1:0] fs, fs_n, xs, xs_n;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) lv_n[i] = lv[i];
    mprv_n = mprv;
    fs_n   = fs;
    xs_n   = xs;
    if (push) begin
      for (int i = DEPTH - 1; i > 0; i--) lv_n[i] = lv[i-1];
      lv_n[0] = mk_lvl(PRV_M, 1'b0);
      mprv_n  = 1'b0;
    end else if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) lv_n[i] = lv[i+1];
      lv_n[DEPTH-1] = mk_lvl(PRV_U, 1'b1);
    end else if (wr) begin
      if (wr_sv) begin
        lv_n[0].ie  = wr_data[SV_IE];
        lv_n[1].ie  = wr_data[SV_PIE];
        lv_n[1].prv = prv_pick(lv[1].prv, wr_data[SV_PS +: 2]);
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          lv_n[i].ie  = wr_data[LVL_W*i];
          lv_n[i].prv = prv_pick(lv[i].prv, wr_data[LVL_W*i+1 +: 2]);
        end
        mprv_n = wr_data[F_MPRV];
        fs_n   = wr_data[F_FS +: 2];
        xs_n   = wr_data[F_XS +: 2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lv[0] <= mk_lvl(PRV_M, 1'b0);
      for (int i = 1; i < DEPTH; i++) lv[i] <= mk_lvl(PRV_S, 1'b0);
      mprv <= 1'b0;
      fs   <= 2'd0;
      xs   <= 2'd0;
    end else begin
      for (int i = 0; i < DEPTH; i++) lv[i] <= lv_n[i];
      mprv <= mprv_n;
      fs   <= fs_n;
      xs   <= xs_n;
    end
  end

  always_comb begin
    status = '0;
    for (int i = 0; i < DEPTH; i++) begin
      status[LVL_W*i]          = lv[i].ie;
      status[LVL_W*i+1 +: 2]   = lv[i].prv;
    end
    status[F_MPRV]    = mprv;
    status[F_FS +: 2] = fs;
    status[F_XS +: 2] = xs;
    status[XLEN-1]    = is_dirty(fs, xs);
  end

  assign cur_prv = lv[0].prv;

  AST_PUSH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (lv[0].prv == PRV_M) && !lv[0].ie && !mprv);  // R2
  AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (lv[1] == $past(lv[0])) && (lv[2] == $past(lv[1])));  // R2
  AST_POP_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (lv[2].prv == PRV_U) && lv[2].ie && (lv[0] == $past(lv[1])));  // R3
  AST_PRV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    prv_ok(lv[0].prv) && prv_ok(lv[1].prv) && prv_ok(lv[2].prv));  // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop && !wr) |=> $stable(status));  // R11

endmodule

// File: rtl/ps_vector.sv
module ps_vector
  import privstk_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] VEC_BASE = 'h200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap,
  input  logic [XLEN-1:0] cause_in,
  input  logic [XLEN-1:0] pc_in,
  input  logic [1:0]      cur_prv,
  output logic [XLEN-1:0] pc_o,
  output logic            pc_load,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o
);

  localparam logic [XLEN-1:0] RST_PC = VEC_BASE + XLEN'('h100);

  logic [XLEN-1:0] handler;
  assign handler = VEC_BASE + XLEN'(vec_off(cur_prv));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_o    <= RST_PC;
      pc_load <= 1'b0;
      cause_o <= '0;
      epc_o   <= '0;
    end else begin
      pc_load <= trap;
      if (trap) begin
        pc_o    <= handler;
        cause_o <= cause_in;
        epc_o   <= pc_in;
      end
    end
  end

  AST_VEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (pc_o == VEC_BASE + XLEN'($past(cur_prv)) * XLEN'(64)));  // R4
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> pc_load);  // R4
  AST_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |=> !pc_load && $stable(pc_o));  // R4
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |=> $stable(cause_o) && $stable(epc_o));  // R5
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (cause_o == $past(cause_in)) && (epc_o == $past(pc_in)));  // R5

endmodule

// File: rtl/priv_stack_unit.sv
module priv_stack_unit
  import privstk_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] VEC_BASE = 'h200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_i,
  input  logic [XLEN-1:0] trap_cause_i,
  input  logic [XLEN-1:0] trap_pc_i,
  input  logic            ret_i,
  input  logic            wr_en_i,
  input  logic            wr_sview_i,
  input  logic [XLEN-1:0] wr_data_i,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] pc_o,
  output logic            pc_load_o
);

  logic       ev_push, ev_pop, ev_wr;
  logic [1:0] cur_prv;

  assign ev_push = trap_i;
  assign ev_pop  = ret_i & ~trap_i;
  assign ev_wr   = wr_en_i & ~trap_i & ~ret_i;

  ps_stack #(.XLEN(XLEN)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (ev_push),
    .pop     (ev_pop),
    .wr      (ev_wr),
    .wr_sv   (wr_sview_i),
    .wr_data (wr_data_i),
    .cur_prv (cur_prv),
    .status  (status_o)
  );

  ps_vector #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_vec (
    .clk      (clk),
    .rst_n    (rst_n),
    .trap     (ev_push),
    .cause_in (trap_cause_i),
    .pc_in    (trap_pc_i),
    .cur_prv  (cur_prv),
    .pc_o     (pc_o),
    .pc_load  (pc_load_o),
    .cause_o  (cause_o),
    .epc_o    (epc_o)
  );

  AST_TRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && ret_i) |=> (status_o[2:1] == PRV_M) && !status_o[0] && pc_load_o);  // R6
  AST_DIRTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[XLEN-1] == ((status_o[F_FS +: 2] == 2'd3) || (status_o[F_XS +: 2] == 2'd3)));  // R9

endmodule

// File: tb/sim_priv_stack_unit.sv
module sim_priv_stack_unit;

  localparam int NV = 17;

  typedef struct packed {
    logic        trap;
    logic        ret;
    logic        wen;
    logic        sv;
    logic [31:0] data;
    logic [31:0] st;
    logic [31:0] pc;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,32'h0000038B,32'h0000038B,32'h300}, // R7 machine write
    '{1'b1,1'b0,1'b0,1'b0,32'h0,       32'h0000005E,32'h240}, // R2 push from S
    '{1'b1,1'b0,1'b0,1'b0,32'h0,       32'h000000F6,32'h2C0}, // R2 push from M
    '{1'b0,1'b1,1'b0,1'b0,32'h0,       32'h0000005E,32'h2C0}, // R3 pop
    '{1'b0,1'b1,1'b0,1'b0,32'h0,       32'h0000004B,32'h2C0}, // R3 pop
    '{1'b0,1'b1,1'b0,1'b0,32'h0,       32'h00000049,32'h2C0}, // R3 pop fills user
    '{1'b1,1'b0,1'b0,1'b0,32'h0,       32'h0000004E,32'h200}, // R4 push from U
    '{1'b0,1'b0,1'b1,1'b0,32'h00000D34,32'h80000C36,32'h200}, // R8 R9 reserved prv kept, fs dirty
    '{1'b0,1'b0,1'b1,1'b0,32'h00003496,32'h80003496,32'h200}, // R9 xs dirty
    '{1'b0,1'b0,1'b1,1'b0,32'h00102892,32'h00002892,32'h200}, // R7 R9 upper bits ignored, no dirty
    '{1'b0,1'b0,1'b1,1'b1,32'h00000012,32'h0000288B,32'h200}, // R10 supervisor view
    '{1'b0,1'b0,1'b1,1'b1,32'h00000200,32'h00002882,32'h200}, // R10 R8 reserved ps kept
    '{1'b0,1'b0,1'b1,1'b1,32'h00000302,32'h000028B3,32'h200}, // R10 ps machine
    '{1'b1,1'b1,1'b0,1'b0,32'h0,       32'h0000299E,32'h240}, // R6 trap beats return
    '{1'b1,1'b0,1'b1,1'b0,32'h0,       32'h000028F6,32'h2C0}, // R11 write during trap
    '{1'b0,1'b1,1'b1,1'b0,32'h0,       32'h0000285E,32'h2C0}, // R11 write during return
    '{1'b0,1'b0,1'b0,1'b0,32'hFFFFFFFF,32'h0000285E,32'h2C0}  // R11 data without enable
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_i = 1'b0, ret_i = 1'b0, wr_en_i = 1'b0, wr_sview_i = 1'b0;
  logic [31:0] trap_cause_i = '0, trap_pc_i = '0, wr_data_i = '0;
  logic [31:0] status_o, cause_o, epc_o, pc_o;
  logic        pc_load_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  priv_stack_unit u0 (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .trap_cause_i(trap_cause_i),
    .trap_pc_i(trap_pc_i), .ret_i(ret_i), .wr_en_i(wr_en_i), .wr_sview_i(wr_sview_i),
    .wr_data_i(wr_data_i), .status_o(status_o), .cause_o(cause_o), .epc_o(epc_o),
    .pc_o(pc_o), .pc_load_o(pc_load_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic check_reset();
    check("R1 status", status_o, 32'h00000096);
    check("R1 pc", pc_o, 32'h00000300);
    check("R1 cause", cause_o, 32'h0);
    check("R1 epc", epc_o, 32'h0);
    check("R1 pc_load", {31'b0, pc_load_o}, 32'h0);
  endtask

  initial begin
    logic [31:0] exp_cause, exp_epc;
    exp_cause = '0;
    exp_epc   = '0;
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check_reset();

    for (int i = 0; i < NV; i++) begin
      trap_i       = TBL[i].trap;
      ret_i        = TBL[i].ret;
      wr_en_i      = TBL[i].wen;
      wr_sview_i   = TBL[i].sv;
      wr_data_i    = TBL[i].data;
      trap_cause_i = 32'hC000_0000 | 32'(i);
      trap_pc_i    = 32'h8000_1000 + 32'(4 * i);
      if (TBL[i].trap) begin
        exp_cause = trap_cause_i;
        exp_epc   = trap_pc_i;
      end
      @(negedge clk);
      trap_i = 1'b0; ret_i = 1'b0; wr_en_i = 1'b0; wr_sview_i = 1'b0;
      check($sformatf("R2 R3 R7 status vec %0d", i), status_o, TBL[i].st);
      check($sformatf("R4 pc vec %0d", i), pc_o, TBL[i].pc);
      check($sformatf("R4 pc_load vec %0d", i), {31'b0, pc_load_o}, {31'b0, TBL[i].trap});
      check($sformatf("R5 cause vec %0d", i), cause_o, exp_cause);
      check($sformatf("R5 epc vec %0d", i), epc_o, exp_epc);
    end

    @(negedge clk);
    check("R4 pc_load drops", {31'b0, pc_load_o}, 32'h0);

    rst_n = 1'b0;
    @(negedge clk);
    check_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule